// File: doc/BRIEF.md
# Residue-Arithmetic FIR Filter

This block is an N-tap finite impulse response filter whose arithmetic runs in a residue number system with three channels. The moduli are 7, 15 and 16 by default, and they must be pairwise coprime. Each accepted binary sample is split into three small residues, one per channel. Each channel runs its own transposed-form filter using modular multiply-accumulate taps. No channel passes a carry or any other data to another channel. A Chinese-remainder stage then rebuilds the binary result from the three channel outputs.

The block is used with the product of the moduli (the dynamic range) chosen large enough for the largest accumulated output. With the defaults, 4-bit samples and four taps, that range is 1680. Software or a controller writes the coefficients as residue triples through a write port, one tap at a time. Samples are then streamed in on a valid-qualified input. Each result appears with its own one-cycle valid flag, a fixed number of cycles after its sample.

Top module: `rns_fir`

## Requirements
- R1: Every accepted sample enters each channel as the sample taken modulo that channel's modulus. No channel residue ever reaches its modulus. With coefficient 1 on tap 0 and 0 elsewhere, a sample comes back unchanged.
- R2: For the n-th accepted sample, out_data equals (sum over k of c_k(n-k)·x(n-k)) mod M, where M = MOD0·MOD1·MOD2 and x(j) is the j-th accepted sample. Here c_k(j) is the integer in [0, M) whose residues tap k held when sample j was accepted. Samples before the last reset count as 0, and cycles without in_valid do not advance the filter.
- R3: out_valid is high for exactly one cycle, 5 clock edges after each edge at which in_valid was sampled high, and is low at all other times. The 5 cycles are made of 2 forward-conversion stages, 1 filter stage and 2 reverse-conversion stages.
- R4: out_data keeps its value on every cycle in which out_valid is low.
- R5: rst is synchronous and active high. It clears all coefficients, all partial sums and all samples in flight. After reset, out_valid is 0 and out_data is 0, and samples accepted before any coefficient write produce 0.
- R6: coef_wr writes the residue triple into tap coef_tap. coef_r0, coef_r1 and coef_r2 feed the channels of MOD0, MOD1 and MOD2, and tap 0 weights the newest sample. Each residue is stored reduced modulo its channel's modulus, so 9 on the MOD0=7 channel acts as 2. A write issued two or more cycles after the last accepted sample applies to every later sample.
- R7: When the true weighted sum is M or more, the result wraps modulo M. out_data is always below M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on in_data is accepted this cycle |
| in_data | input | IN_W | Unsigned binary sample |
| coef_wr | input | 1 | Coefficient residue write strobe |
| coef_tap | input | TAP_W | Tap index written, 0 = newest sample |
| coef_r0 | input | RES_W | Coefficient residue for the MOD0 channel |
| coef_r1 | input | RES_W | Coefficient residue for the MOD1 channel |
| coef_r2 | input | RES_W | Coefficient residue for the MOD2 channel |
| out_valid | output | 1 | Result on out_data is new this cycle |
| out_data | output | OUT_W | Reconstructed binary result, below M |

## Verification
A corrupted residue, partial sum or stored coefficient in one channel does not stay inside that channel. Through the reconstruction it shows up as a wrong out_data value, usually far from the true result, 5 cycles after the next accepted sample. It keeps showing in each of the following outputs until the bad term has left the tap chain, which takes up to NTAPS outputs. A lost or extra valid bit shows up at once as an out_valid pulse at the wrong cycle. A filter that advances on idle cycles corrupts the very next result. A stored coefficient that was not reduced gives a result that is wrong modulo M in the output of the first sample it touches.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;

  // product of two residues folded back below the modulus
  function automatic int unsigned rmod_mul(int unsigned a, int unsigned b, int unsigned m);
    return (a * b) % m;
  endfunction

  // sum of two residues, both already below m; one conditional subtract
  function automatic int unsigned rmod_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? (s - m) : s;
  endfunction

  // multiplicative inverse by search; elaboration-time only
  function automatic int unsigned mod_inv(int unsigned a, int unsigned m);
    int unsigned found;
    found = 0;
    for (int unsigned k = 1; k < m; k++) begin
      if (found == 0 && ((a * k) % m) == 1) found = k;
    end
    return found;
  endfunction

  // reconstruction weight: (dyn/m) * ((dyn/m)^-1 mod m)
  function automatic int unsigned crt_weight(int unsigned m, int unsigned dyn);
    int unsigned q;
    q = dyn / m;
    return q * mod_inv(q % m, m);
  endfunction

endpackage

// File: rtl/rnsf_fwd_conv.sv
module rnsf_fwd_conv
  import rns_fir_pkg::*;
#(
  parameter int          IN_W  = 4,
  parameter int          RES_W = 4,
  parameter int unsigned MOD0  = 7,
  parameter int unsigned MOD1  = 15,
  parameter int unsigned MOD2  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_data,
  output logic               res_valid,
  output logic [3*RES_W-1:0] res_bus
);
  localparam int unsigned MODS [3] = '{MOD0, MOD1, MOD2};

  logic            cap_valid;
  logic [IN_W-1:0] cap_data;

  // stage 1: capture the binary sample
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      cap_valid <= in_valid;
      cap_data  <= in_data;
    end
  end

  // stage 2: one residue per channel
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_bus   <= '0;
    end else begin
      res_valid <= cap_valid;
      for (int c = 0; c < 3; c++)
        res_bus[c*RES_W +: RES_W] <= RES_W'(32'(cap_data) % MODS[c]);
    end
  end
endmodule

// File: rtl/rnsf_channel.sv
module rnsf_channel
  import rns_fir_pkg::*;
#(
  parameter int unsigned MOD   = 7,
  parameter int          NTAPS = 4,
  parameter int          RES_W = 4,
  parameter int          TAP_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [RES_W-1:0] x,
  input  logic             coef_wr,
  input  logic [TAP_W-1:0] coef_tap,
  input  logic [RES_W-1:0] coef_val,
  output logic [RES_W-1:0] y
);
  logic [RES_W-1:0] coef_q  [NTAPS];
  logic [RES_W-1:0] psum_q  [NTAPS-1];
  logic [RES_W-1:0] tap_out [NTAPS];

  // each tap: coefficient times broadcast input plus the partial sum behind it
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    if (k == NTAPS - 1) begin : g_last
      assign tap_out[k] = RES_W'(rmod_mul(32'(coef_q[k]), 32'(x), MOD));
    end else begin : g_mid
      assign tap_out[k] = RES_W'(rmod_add(rmod_mul(32'(coef_q[k]), 32'(x), MOD),
                                          32'(psum_q[k]), MOD));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++)     coef_q[k] <= '0;
      for (int k = 0; k < NTAPS - 1; k++) psum_q[k] <= '0;
      y <= '0;
    end else begin
      if (coef_wr && (32'(coef_tap) < NTAPS))
        coef_q[coef_tap] <= RES_W'(32'(coef_val) % MOD);
      if (en) begin
        for (int k = 0; k < NTAPS - 1; k++) psum_q[k] <= tap_out[k+1];
        y <= tap_out[0];
      end
    end
  end
endmodule

// File: rtl/rnsf_crt.sv
module rnsf_crt
  import rns_fir_pkg::*;
#(
  parameter int          RES_W = 4,
  parameter int          OUT_W = 11,
  parameter int unsigned MOD0  = 7,
  parameter int unsigned MOD1  = 15,
  parameter int unsigned MOD2  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [3*RES_W-1:0] res_bus,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data
);
  localparam int unsigned DYN = MOD0 * MOD1 * MOD2;
  localparam int unsigned WGT [3] = '{crt_weight(MOD0, DYN),
                                      crt_weight(MOD1, DYN),
                                      crt_weight(MOD2, DYN)};

  logic             prod_valid;
  logic [OUT_W-1:0] prod_q [3];
  logic [OUT_W+1:0] prod_sum;

  // stage 1: weight each residue and fold below the dynamic range
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_valid <= 1'b0;
      for (int c = 0; c < 3; c++) prod_q[c] <= '0;
    end else begin
      prod_valid <= in_valid;
      for (int c = 0; c < 3; c++)
        prod_q[c] <= OUT_W'((64'(res_bus[c*RES_W +: RES_W]) * 64'(WGT[c])) % 64'(DYN));
    end
  end

  assign prod_sum = {2'b00, prod_q[0]} + {2'b00, prod_q[1]} + {2'b00, prod_q[2]};

  // stage 2: three terms below DYN sum below 3*DYN, so two compares suffice
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= prod_valid;
      if (32'(prod_sum) >= 2 * DYN)  out_data <= OUT_W'(32'(prod_sum) - 2 * DYN);
      else if (32'(prod_sum) >= DYN) out_data <= OUT_W'(32'(prod_sum) - DYN);
      else                           out_data <= OUT_W'(prod_sum);
    end
  end
endmodule

// File: rtl/rns_fir.sv
module rns_fir
  import rns_fir_pkg::*;
#(
  parameter int unsigned MOD0  = 7,
  parameter int unsigned MOD1  = 15,
  parameter int unsigned MOD2  = 16,
  parameter int          NTAPS = 4,
  parameter int          IN_W  = 4,
  localparam int unsigned DYN   = MOD0 * MOD1 * MOD2,
  localparam int unsigned MMAX  = (MOD0 > MOD1) ? ((MOD0 > MOD2) ? MOD0 : MOD2)
                                                : ((MOD1 > MOD2) ? MOD1 : MOD2),
  localparam int          RES_W = $clog2(MMAX),
  localparam int          OUT_W = $clog2(DYN),
  localparam int          TAP_W = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             coef_wr,
  input  logic [TAP_W-1:0] coef_tap,
  input  logic [RES_W-1:0] coef_r0,
  input  logic [RES_W-1:0] coef_r1,
  input  logic [RES_W-1:0] coef_r2,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned MODS [3] = '{MOD0, MOD1, MOD2};

  // named internal events, observed by the bound checker
  logic               chan_en;
  logic [3*RES_W-1:0] res_bus;
  logic [3*RES_W-1:0] ych_bus;
  logic               ych_valid;
  logic [3*RES_W-1:0] coef_bus;

  assign coef_bus = {coef_r2, coef_r1, coef_r0};

  rnsf_fwd_conv #(
    .IN_W(IN_W), .RES_W(RES_W), .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2)
  ) u_fwd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .res_valid(chan_en), .res_bus(res_bus)
  );

  for (genvar c = 0; c < 3; c++) begin : g_ch
    rnsf_channel #(
      .MOD(MODS[c]), .NTAPS(NTAPS), .RES_W(RES_W), .TAP_W(TAP_W)
    ) u_ch (
      .clk(clk), .rst(rst), .en(chan_en),
      .x(res_bus[c*RES_W +: RES_W]),
      .coef_wr(coef_wr), .coef_tap(coef_tap),
      .coef_val(coef_bus[c*RES_W +: RES_W]),
      .y(ych_bus[c*RES_W +: RES_W])
    );
  end

  // the channel stage takes one cycle
  always_ff @(posedge clk) begin
    if (rst) ych_valid <= 1'b0;
    else     ych_valid <= chan_en;
  end

  rnsf_crt #(
    .RES_W(RES_W), .OUT_W(OUT_W), .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2)
  ) u_crt (
    .clk(clk), .rst(rst), .in_valid(ych_valid), .res_bus(ych_bus),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/rns_fir_chk.sv
module rns_fir_chk #(
  parameter int unsigned MOD0  = 7,
  parameter int unsigned MOD1  = 15,
  parameter int unsigned MOD2  = 16,
  parameter int          RES_W = 4,
  parameter int          OUT_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               out_valid,
  input logic [OUT_W-1:0]   out_data,
  input logic [3*RES_W-1:0] res_bus,
  input logic               chan_en,
  input logic [3*RES_W-1:0] ych_bus
);
  localparam int unsigned DYN = MOD0 * MOD1 * MOD2;

  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  logic [RES_W-1:0] r0, r1, r2, y0, y1, y2;
  assign r0 = res_bus[0*RES_W +: RES_W];
  assign r1 = res_bus[1*RES_W +: RES_W];
  assign r2 = res_bus[2*RES_W +: RES_W];
  assign y0 = ych_bus[0*RES_W +: RES_W];
  assign y1 = ych_bus[1*RES_W +: RES_W];
  assign y2 = ych_bus[2*RES_W +: RES_W];

  // R3
  lat_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

  // R1
  res_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(r0) < MOD0) && (32'(r1) < MOD1) && (32'(r2) < MOD2)
    && (32'(y0) < MOD0) && (32'(y1) < MOD1) && (32'(y2) < MOD2));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(out_data) < DYN);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 3'd1) && !out_valid) |-> $stable(out_data));

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 3'd1) && !$past(chan_en)) |-> $stable(ych_bus));

  // R2
  crt_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2) |-> ((32'(out_data) % MOD0 == 32'($past(y0, 2)))
                    && (32'(out_data) % MOD1 == 32'($past(y1, 2)))
                    && (32'(out_data) % MOD2 == 32'($past(y2, 2)))));
endmodule

bind rns_fir rns_fir_chk #(
  .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2), .RES_W(RES_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .res_bus(res_bus), .chan_en(chan_en), .ych_bus(ych_bus)
);

// File: tb/rns_fir_tb.sv
module rns_fir_tb;
  localparam int M0 = 7, M1 = 15, M2 = 16;
  localparam int NT = 4, IW = 4, RW = 4, OW = 11, TW = 2;
  localparam int DYN = M0 * M1 * M2;

  localparam int NV = 14;
  localparam int VX [NV] = '{4, 15, 0, 7, 1, 9, 12, 3, 15, 15, 2, 8, 0, 11};
  localparam int VG [NV] = '{0, 0, 2, 0, 1, 0, 0, 3, 0, 0, 0, 5, 0, 6};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, in_valid = 1'b0, coef_wr = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic [TW-1:0] coef_tap = '0;
  logic [RW-1:0] coef_r0 = '0, coef_r1 = '0, coef_r2 = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  rns_fir #(.MOD0(M0), .MOD1(M1), .MOD2(M2), .NTAPS(NT), .IN_W(IW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_wr(coef_wr), .coef_tap(coef_tap), .coef_r0(coef_r0),
    .coef_r1(coef_r1), .coef_r2(coef_r2),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    checks = 0, errors = 0, cyc = 0, last_out = 0;
  string tag = "R2";
  int    hcur [NT];
  int    hx   [NT];
  int    hh   [NT][NT];
  int    exp_val [$];
  int    exp_due [$];

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor: valid timing (R3), value (tag), hold between results (R4)
  always @(negedge clk) begin : mon
    bit due_now;
    if (!rst) begin
      due_now = (exp_due.size() > 0) && (exp_due[0] == cyc);
      if (due_now || out_valid) begin
        checks++;
        if (out_valid != due_now) begin
          errors++;
          $display("FAIL R3: out_valid=%0b expected %0b at cycle %0d", out_valid, due_now, cyc);
          if (due_now) begin void'(exp_val.pop_front()); void'(exp_due.pop_front()); end
        end else begin
          if (int'(out_data) != exp_val[0]) begin
            errors++;
            $display("FAIL %s: out_data=%0d expected %0d at cycle %0d", tag, out_data, exp_val[0], cyc);
          end
          void'(exp_val.pop_front()); void'(exp_due.pop_front());
        end
        last_out = int'(out_data);
      end else begin
        checks++;
        if (int'(out_data) != last_out) begin
          errors++;
          $display("FAIL R4: out_data=%0d expected held %0d at cycle %0d", out_data, last_out, cyc);
          last_out = int'(out_data);
        end
      end
    end
  end

  task automatic model_clear();
    for (int k = 0; k < NT; k++) begin
      hcur[k] = 0; hx[k] = 0;
      for (int j = 0; j < NT; j++) hh[k][j] = 0;
    end
    exp_val.delete(); exp_due.delete();
    last_out = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; coef_wr = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    rst = 1'b0;
  endtask

  // each sample is weighted by the coefficients in force when it was accepted
  task automatic send(input int x, input int gap);
    int y;
    y = 0;
    for (int k = NT - 1; k > 0; k--) begin
      hx[k] = hx[k-1];
      for (int j = 0; j < NT; j++) hh[k][j] = hh[k-1][j];
    end
    hx[0] = x;
    for (int j = 0; j < NT; j++) hh[0][j] = hcur[j];
    for (int k = 0; k < NT; k++) y += hh[k][k] * hx[k];
    exp_val.push_back(y % DYN);
    exp_due.push_back(cyc + 5);
    in_valid = 1'b1; in_data = IW'(x);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // residue triple write; the model finds the integer with those residues
  task automatic load_res(input int tap, input int a, input int b, input int c);
    int h;
    h = -1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < DYN; v++)
      if (h < 0 && v % M0 == a % M0 && v % M1 == b % M1 && v % M2 == c % M2) h = v;
    hcur[tap] = h;
    coef_wr = 1'b1; coef_tap = TW'(tap);
    coef_r0 = RW'(a); coef_r1 = RW'(b); coef_r2 = RW'(c);
    @(negedge clk);
    coef_wr = 1'b0;
  endtask

  task automatic load_bin(input int tap, input int h);
    load_res(tap, h % M0, h % M1, h % M2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();
    // R5: reset state at the ports
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R5: out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
    end
    // R5: coefficients cleared, so results are zero
    tag = "R5";
    send(9, 0); send(15, 6);

    // R2: table walk with gaps and back-to-back samples
    tag = "R2";
    load_bin(0, 3); load_bin(1, 5); load_bin(2, 2); load_bin(3, 7);
    for (int i = 0; i < NV; i++) send(VX[i], VG[i]);
    repeat (4) @(negedge clk);

    // R1: unit tap 0 returns the sample, including the largest one
    tag = "R1";
    do_reset();
    load_bin(0, 1);
    send(13, 1); send(15, 1); send(0, 6);

    // R6: tap 2 weights the sample two accepted samples back
    tag = "R6";
    do_reset();
    load_bin(2, 11);
    send(1, 0); send(0, 0); send(0, 0); send(0, 6);
    // R6: over-range residues stored reduced (9 on modulus 7, 15 on modulus 15)
    load_res(0, 9, 15, 15);
    send(1, 0); send(3, 0); send(0, 6);
    // R6: change a tap between bursts
    load_bin(1, 4);
    send(2, 0); send(5, 1); send(7, 6);

    // R7: large coefficients force the sum past the dynamic range
    tag = "R7";
    do_reset();
    load_bin(0, 1500); load_bin(1, 1600); load_bin(3, 1679);
    send(15, 0); send(15, 0); send(14, 0); send(15, 6);

    // R5: reset with samples in flight drops them
    tag = "R5";
    send(5, 0); send(6, 0);
    do_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R5: out_valid=%0b expected 0 after reset flush", out_valid);
      end
    end
    send(8, 6);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_due.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d results outstanding, expected 0", exp_due.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule